// File: doc/BRIEF.md
# Ethernet receive protocol controller

This block is the receive protocol engine of a 10 Mb/s serial Ethernet MAC. It runs on the receive bit clock and takes one data bit per clock while the carrier input is high. It hunts for the start-of-frame delimiter and discards every bit up to and including it. It then packs the following bits into bytes, least significant bit first, and writes each byte to a receive FIFO with a one-cycle valid strobe.

When the carrier falls, the block drops any leftover bits that do not fill a byte. It then raises a one-cycle end-of-frame strobe. With that strobe it gives a CRC-32 pass/fail flag and, for frames shorter than the minimum, a reject strobe that tells the FIFO to discard the frame. A frame that grows past the maximum length raises a babble interrupt, and the rest of that frame is thrown away. A byte counter gives the frame length. The block is ready to hunt for the next delimiter in the cycle after the end-of-frame.

Top module: `eth_rx_proto`

## Requirements
- R1: After reset, rx_byte_vld, rx_eof, rx_reject, rx_crc_err and babble_irq are 0 and rx_len is 0.
- R2: While hunting, the bits received with rx_crs high are matched against the delimiter bit sequence 1,0,1,0,1,0,1,1 in arrival order (octet value 0xD5 with the first bit as bit 0). No bit up to and including the delimiter reaches rx_byte, and the first byte written is built from the 8 bits that follow the delimiter.
- R3: After the delimiter, every 8 bits received give exactly one rx_byte_vld pulse. The first bit of the group is rx_byte[0] and the last is rx_byte[7]. Bytes are written in arrival order.
- R4: If 1 to 7 bits are left over when rx_crs falls, they are dropped. They produce no rx_byte_vld pulse and do not change the length, CRC or reject results.
- R5: When rx_crs is sampled low after a delimiter, rx_eof is high for exactly one cycle, in the clock cycle after that sample. rx_byte_vld is low in that cycle.
- R6: If the frame ends with fewer than MIN_BYTES bytes (default 64), rx_reject pulses together with rx_eof. Otherwise rx_reject stays 0.
- R7: When byte MAX_BYTES+1 (default 1518) completes, babble_irq pulses for one cycle and no further rx_byte_vld pulse occurs for that frame. At carrier fall, rx_eof pulses with rx_reject 0 and rx_crc_err 1, and rx_len reads MAX_BYTES.
- R8: rx_len is cleared when a delimiter is found and counts the bytes written. After rx_eof it holds the frame's byte count until the next delimiter.
- R9: With rx_eof, rx_crc_err is 1 when the bit-reflected CRC-32 register is not 0xDEBB20E3. That register uses polynomial 0xEDB88320, is preset to all ones and is run over every byte written. 0xDEBB20E3 is the reflected form of the residue 0xC704DD7B. rx_crc_err holds until the next rx_eof.
- R10: A frame that starts 24 bit times after the previous frame's carrier fall is received completely and correctly.
- R11: If the carrier falls before a delimiter is found, no strobe of any kind is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_crs | input | 1 | Carrier / receive enable; a bit is taken each cycle it is high |
| rx_bit | input | 1 | Serial receive data |
| rx_byte | output | 8 | Byte to the receive FIFO |
| rx_byte_vld | output | 1 | One-cycle write strobe for rx_byte |
| rx_eof | output | 1 | One-cycle end-of-frame strobe |
| rx_reject | output | 1 | Discard-frame strobe, only with rx_eof |
| rx_crc_err | output | 1 | CRC failure flag, updated with rx_eof |
| rx_len | output | LEN_W | Byte count of the current or last frame |
| babble_irq | output | 1 | One-cycle pulse when a frame exceeds the maximum length |

## Verification
The bench uses a reduced configuration with minimum 8 and maximum 20 bytes. It sweeps every frame length from 0 to 23 bytes against every dribble count from 0 to 7. Frames of five or more bytes carry a valid FCS, so the sweep separates the runt side, the normal middle and the giant side of both thresholds, one byte either side of each. Frames with one corrupted byte tell a real CRC check apart from one that always passes. Preambles with no delimiter, followed by a normal frame, check that hunting neither raises false strobes nor misses the next frame. Every frame follows the previous one after a 24-bit gap, so recovery is covered throughout.

// File: rtl/eth_rx_pkg.sv
// Package: shared types and CRC arithmetic for the Ethernet receive engine.
// Assumes bits arrive least significant first, as on the 10 Mb/s serial line.
package eth_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_DROP = 2'd2
    } rx_state_t;

    localparam logic [7:0]  SFD_OCTET   = 8'hD5;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0] CRC_RESID_R = 32'hDEBB20E3;

    // Advance a reflected CRC-32 register by one byte, bit 0 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_R;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxp_shifter.sv
// Module: serial-in window and byte-phase counter.
// Shifts one bit per enabled cycle into the top of a W-bit window, so the
// first bit lands at bit 0 after W shifts. The phase counter runs only when
// cnt_en is set and flags the cycle whose bit completes a byte.
// Assumes clr and shift_en are never both high.
module rxp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         cnt_en,
    input  logic         clr,
    input  logic         din,
    output logic [W-1:0] win,
    output logic         byte_done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    assign win       = {din, sh_q[W-1:1]};
    assign byte_done = shift_en && cnt_en && (cnt_q == CW'(W - 1));

    // Window register: load the shifted value, clear while the carrier is off.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (clr)      sh_q <= '0;
        else if (shift_en) sh_q <= win;
    end

    // Phase counter: counts bits inside a byte, wraps at each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clr)                cnt_q <= '0;
        else if (byte_done)          cnt_q <= '0;
        else if (shift_en && cnt_en) cnt_q <= cnt_q + 1'b1;
    end

    AST_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/rxp_crc.sv
// Module: byte-wide CRC-32 checker.
// Presets to all ones on init, folds in one byte per upd, and reports
// whether the register equals the reflected 802.3 residue.
// Assumes init and upd are never both high.
module rxp_crc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       upd,
    input  logic [7:0] data,
    output logic       crc_ok
);
    import eth_rx_pkg::*;

    logic [31:0] crc_q;

    assign crc_ok = (crc_q == CRC_RESID_R);

    // CRC register: preset at frame start, advance one byte per written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= '1;
        else if (init) crc_q <= '1;
        else if (upd)  crc_q <= crc32_step(crc_q, data);
    end

    AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == 32'hFFFF_FFFF)); // R9

endmodule

// File: rtl/rxp_len.sv
// Module: saturating frame byte counter.
// Cleared at frame start, incremented per written byte, never exceeds MAX.
module rxp_len #(
    parameter int MAX = 1518,
    parameter int W   = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] len,
    output logic         at_max
);
    assign at_max = (len == W'(MAX));

    // Byte count: clear on delimiter, count written bytes up to the cap.
    always_ff @(posedge clk) begin
        if (!rst_n)              len <= '0;
        else if (clr)            len <= '0;
        else if (inc && !at_max) len <= len + 1'b1;
    end

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        len <= W'(MAX)); // R7

endmodule

// File: rtl/eth_rx_proto.sv
// Module: Ethernet receive protocol controller (top).
// Takes one serial bit per clock while rx_crs is high. It finds the start
// delimiter, writes the following bytes to a FIFO port and ends the frame
// when the carrier falls. With the end strobe it reports the runt reject and
// the CRC result, and it cuts off frames longer than MAX_BYTES.
// Assumes the clock is the receive bit clock (one bit per cycle).
module eth_rx_proto #(
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_crs,
    input  logic             rx_bit,
    output logic [7:0]       rx_byte,
    output logic             rx_byte_vld,
    output logic             rx_eof,
    output logic             rx_reject,
    output logic             rx_crc_err,
    output logic [LEN_W-1:0] rx_len,
    output logic             babble_irq
);
    import eth_rx_pkg::*;

    rx_state_t  state;
    logic [7:0] win;
    logic       byte_done;
    logic       sfd_hit;
    logic       wr_byte;
    logic       at_max;
    logic       crc_ok;

    assign sfd_hit = (state == ST_HUNT) && rx_crs && (win == SFD_OCTET);
    assign wr_byte = (state == ST_DATA) && byte_done && !at_max;

    rxp_shifter #(.W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_crs),
        .cnt_en   (state != ST_HUNT),
        .clr      (!rx_crs),
        .din      (rx_bit),
        .win      (win),
        .byte_done(byte_done)
    );

    rxp_len #(.MAX(MAX_BYTES), .W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sfd_hit),
        .inc   (wr_byte),
        .len   (rx_len),
        .at_max(at_max)
    );

    rxp_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (sfd_hit),
        .upd   (wr_byte),
        .data  (win),
        .crc_ok(crc_ok)
    );

    // Frame state: hunt for the delimiter, take data, drop an over-long tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            case (state)
                ST_HUNT: if (sfd_hit) state <= ST_DATA;
                ST_DATA: begin
                    if (!rx_crs)                  state <= ST_HUNT;
                    else if (byte_done && at_max) state <= ST_DROP;
                end
                ST_DROP: if (!rx_crs) state <= ST_HUNT;
                default: state <= ST_HUNT;
            endcase
        end
    end

    // FIFO write port: register each completed byte with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte     <= '0;
            rx_byte_vld <= 1'b0;
        end else begin
            rx_byte_vld <= wr_byte;
            if (wr_byte) rx_byte <= win;
        end
    end

    // Frame-end strobes: eof, runt reject and CRC flag when the carrier drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_eof     <= 1'b0;
            rx_reject  <= 1'b0;
            rx_crc_err <= 1'b0;
        end else begin
            rx_eof    <= 1'b0;
            rx_reject <= 1'b0;
            if (!rx_crs && state == ST_DATA) begin
                rx_eof     <= 1'b1;
                rx_reject  <= (rx_len < LEN_W'(MIN_BYTES));
                rx_crc_err <= !crc_ok;
            end else if (!rx_crs && state == ST_DROP) begin
                rx_eof     <= 1'b1;
                rx_crc_err <= 1'b1;
            end
        end
    end

    // Babble interrupt: pulse when a byte beyond the maximum completes.
    always_ff @(posedge clk) begin
        if (!rst_n) babble_irq <= 1'b0;
        else        babble_irq <= (state == ST_DATA) && byte_done && at_max;
    end

    AST_VLD_EOF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_byte_vld && rx_eof)); // R5
    AST_EOF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |-> !$past(rx_crs)); // R5
    AST_REJ_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reject |-> rx_eof); // R6
    AST_BABBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |=> !babble_irq); // R7
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |=> !rx_byte_vld); // R7
    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && $past(state) == ST_HUNT) |-> $stable(rx_len)); // R8
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HUNT) |-> !(rx_byte_vld || rx_eof)); // R11

endmodule

// File: tb/eth_rx_proto_tb.sv
module eth_rx_proto_tb;

    localparam int MINB = 8;
    localparam int MAXB = 20;
    localparam int LW   = $clog2(MAXB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_crs = 1'b0;
    logic          rx_bit = 1'b0;
    logic [7:0]    rx_byte;
    logic          rx_byte_vld;
    logic          rx_eof;
    logic          rx_reject;
    logic          rx_crc_err;
    logic [LW-1:0] rx_len;
    logic          babble_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] pay [0:31];
    logic [7:0] cap [0:63];
    int cap_n = 0, eof_n = 0, bab_n = 0, evt_n = 0;
    logic last_rej = 1'b0, last_crc = 1'b0;

    always #4 clk = ~clk;

    eth_rx_proto #(.MIN_BYTES(MINB), .MAX_BYTES(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_crs(rx_crs), .rx_bit(rx_bit),
        .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof),
        .rx_reject(rx_reject), .rx_crc_err(rx_crc_err), .rx_len(rx_len),
        .babble_irq(babble_irq)
    );

    // Monitor on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_byte_vld) begin
                if (cap_n < 64) cap[cap_n] = rx_byte;
                cap_n++;
            end
            if (rx_eof) begin
                eof_n++;
                last_rej = rx_reject;
                last_crc = rx_crc_err;
            end
            if (rx_reject && !rx_eof) evt_n++;
            if (babble_irq) bab_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ pay[k][b];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        rx_crs = 1'b1;
        rx_bit = b;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_crs = 1'b0;
            rx_bit = 1'b0;
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; eof_n = 0; bab_n = 0; evt_n = 0;
    endtask

    // Build, send and check one frame of n bytes with drib extra bits.
    task automatic run_frame(input int n, input int drib, input bit bad);
        logic [31:0] f;
        bit giant;
        int deliv, dmis;
        bit e1, e2, exp_crc;
        logic [LW-1:0] len_at_eof;
        for (int i = 0; i < n && i < 32; i++) pay[i] = 8'((i * 37 + n * 11 + 5) & 255);
        if (n >= 5) begin
            f = ~ref_crc(n - 4);
            for (int i = 0; i < 4; i++) pay[n - 4 + i] = f[8*i +: 8];
        end
        if (bad && n > 0) pay[0] = pay[0] ^ 8'h01;
        clear_mon();
        for (int i = 0; i < 7; i++) send_byte(8'h55);
        send_byte(8'hD5);
        for (int i = 0; i < n; i++) send_byte(pay[i]);
        for (int i = 0; i < drib; i++) send_bit(1'(i & 1));
        @(posedge clk); #1;
        rx_crs = 1'b0;
        rx_bit = 1'b0;
        @(negedge clk); e1 = rx_eof;
        @(negedge clk); e2 = rx_eof; len_at_eof = rx_len;
        gap(22);
        giant   = (n > MAXB);
        deliv   = giant ? MAXB : n;
        exp_crc = giant ? 1'b1 : (ref_crc(n) != 32'hDEBB20E3);
        dmis = 0;
        for (int i = 0; i < deliv && i < cap_n; i++) if (cap[i] !== pay[i]) dmis++;
        chk(cap_n == deliv, $sformatf("R3 R4 R10 byte count n=%0d drib=%0d", n, drib), cap_n, deliv);
        chk(dmis == 0, $sformatf("R2 R3 data mismatches n=%0d drib=%0d", n, drib), dmis, 0);
        chk(!e1 && e2, $sformatf("R5 eof timing n=%0d", n), {e1, e2}, 1);
        chk(eof_n == 1, $sformatf("R5 eof count n=%0d", n), eof_n, 1);
        chk(last_rej == (!giant && n < MINB), $sformatf("R6 reject n=%0d", n),
            last_rej, (!giant && n < MINB));
        chk(evt_n == 0, "R6 reject outside eof", evt_n, 0);
        chk(bab_n == (giant ? 1 : 0), $sformatf("R7 babble n=%0d", n), bab_n, giant ? 1 : 0);
        chk(int'(len_at_eof) == deliv && int'(rx_len) == deliv,
            $sformatf("R8 length n=%0d", n), int'(rx_len), deliv);
        chk(last_crc == exp_crc && rx_crc_err == exp_crc,
            $sformatf("R9 crc flag n=%0d bad=%0d", n, bad), rx_crc_err, exp_crc);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_byte_vld && !rx_eof && !rx_reject && !rx_crc_err && !babble_irq && rx_len == 0,
            "R1 reset state", {rx_byte_vld, rx_eof, rx_reject, rx_crc_err, babble_irq}, 0);
        gap(4);

        // R11: preamble with no delimiter gives no strobe.
        clear_mon();
        for (int i = 0; i < 5; i++) send_byte(8'h55);
        send_bit(1'b1);
        gap(24);
        chk(cap_n == 0 && eof_n == 0 && bab_n == 0, "R11 no strobe without delimiter",
            cap_n + eof_n + bab_n, 0);
        chk(rx_len == 0, "R11 R8 length untouched", int'(rx_len), 0);

        // Sweep of lengths and dribble counts, 24-bit gaps between frames (R10).
        for (int n = 0; n <= MAXB + 3; n++)
            for (int d = 0; d < 8; d++)
                run_frame(n, d, 1'b0);

        // Corrupted frames on both sides of the minimum.
        for (int n = 5; n <= MAXB; n++) run_frame(n, 0, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule